// File: doc/BRIEF.md
# Timer Channel Byte Access and Latch Unit

This unit is the host-facing half of one timer channel. An 8-bit host port writes a per-channel configuration byte, initial counts and latch requests; the unit assembles each initial count into a 16-bit count register and signals the counting element when a complete value is ready. It also tracks whether the counting element has taken the newest value yet, and it exports a flag while a two-byte count is half written.

On the read side the unit serves the live count of the counting element, a frozen copy of it, or a status snapshot. The configured access format decides the byte order: low byte only, high byte only, or low then high. Reads and writes keep separate byte pointers, so a read sequence and a write sequence on the same channel can be interleaved. Latch requests follow a first-request-wins rule. A latched status is always returned before a latched count.

The counting modes themselves are not part of this block. The live count, the channel output level and a load strobe arrive as inputs from the counting element.

Top module: `cnt_byte_port`

## Requirements
- R1: A configuration write (`mode_we`) stores `mode_cfg` into `cfg_mode`. Bits 5:4 of that byte are the access format: 01 low byte only, 10 high byte only, 11 low then high. Bits 3:1 are the mode and bit 0 the BCD flag. A configuration write whose access field is 00 changes nothing.
- R2: In a single-byte format a data write completes the count at once. The unused byte of `cr_value` is zero, and `new_count` is high for exactly the one cycle after the write.
- R3: In the two-byte format the first write raises `first_byte_pending` and gives no `new_count`. The second write presents both bytes together on `cr_value`, pulses `new_count` and clears `first_byte_pending`.
- R4: `null_count` is set by a valid configuration write and by a completing data write, and is cleared by `ce_loaded`. When a set and a clear arrive in the same cycle, the set wins.
- R5: While no latch is held, `rd_data` shows a byte of `live_count` selected by the access format and the read pointer. Each read (`rd_en`) advances the pointer in the two-byte format.
- R6: A count latch request freezes `live_count`. Reads return the frozen value until it has been fully read, and after that they follow `live_count` again.
- R7: A count latch request that arrives while a frozen count is still unread has no effect.
- R8: A status latch request captures `{out_level, null_count, cfg_mode}` into bits 7, 6 and 5:0. A further status request before that status is read has no effect.
- R9: When status and count are both latched, the first read returns the status whichever was latched first. The next one or two reads return the frozen count, and later reads return the live count.
- R10: Read and write byte pointers are independent. The sequence read low, write low, read high, write high yields correct bytes on both sides.
- R11: A valid configuration write returns both byte pointers to the low byte and discards any latched count or status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Configuration write strobe |
| mode_cfg | input | 6 | Configuration byte: access, mode, BCD |
| wr_en | input | 1 | Count byte write strobe |
| wr_data | input | 8 | Count byte being written |
| rd_en | input | 1 | Read strobe, consumes the byte on `rd_data` |
| rd_data | output | 8 | Byte currently offered to the host |
| cnt_latch_req | input | 1 | Freeze the live count |
| sts_latch_req | input | 1 | Capture the status byte |
| live_count | input | 16 | Current value of the counting element |
| out_level | input | 1 | Current channel output level |
| ce_loaded | input | 1 | Counting element has taken `cr_value` |
| cr_value | output | 16 | Assembled count register |
| new_count | output | 1 | One-cycle pulse when a complete count is written |
| null_count | output | 1 | Newest count not yet taken by the counting element |
| first_byte_pending | output | 1 | Two-byte count is half written |
| cfg_mode | output | 6 | Stored configuration byte |

## Verification
The bench builds the unit with its default 8-bit byte, which gives a 16-bit count and a 6-bit configuration. With these sizes every access format can be swept against a set of arithmetically generated count values, and every expected byte is derived from a shift and a mask. The small width also puts the exact status byte encoding, the zeroing of unused bytes and the interleaving of read and write pointers within direct reach of the checks.

// File: rtl/cbp_pkg.sv
package cbp_pkg;
  localparam int CFG_W = 6;

  typedef enum logic [1:0] {
    ACC_NONE = 2'b00,
    ACC_LO   = 2'b01,
    ACC_HI   = 2'b10,
    ACC_WORD = 2'b11
  } acc_e;
endpackage

// File: rtl/cbp_wr_seq.sv
module cbp_wr_seq
  import cbp_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  acc_e              acc,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              ce_loaded,
  output logic [CNT_W-1:0]  cr_value,
  output logic              new_count,
  output logic              null_count,
  output logic              first_pend
);
  logic [BYTE_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic              ptr_q, ptr_d;
  logic              pulse_q, pulse_d;
  logic              null_q, null_d;
  logic              done_wr;
  logic              cr_en;

  assign cr_en = wr_en & ~cfg_we;

  always_comb begin
    lo_d    = lo_q;
    hi_d    = hi_q;
    ptr_d   = ptr_q;
    done_wr = 1'b0;
    if (cfg_we) begin
      ptr_d = 1'b0;
    end else if (wr_en) begin
      case (acc)
        ACC_LO: begin
          lo_d    = wr_data;
          hi_d    = '0;
          done_wr = 1'b1;
        end
        ACC_HI: begin
          hi_d    = wr_data;
          lo_d    = '0;
          done_wr = 1'b1;
        end
        ACC_WORD: begin
          if (!ptr_q) begin
            lo_d  = wr_data;
            ptr_d = 1'b1;
          end else begin
            hi_d    = wr_data;
            ptr_d   = 1'b0;
            done_wr = 1'b1;
          end
        end
        default: begin
          done_wr = 1'b0;
        end
      endcase
    end
    pulse_d = done_wr;
    null_d  = null_q;
    if (ce_loaded) null_d = 1'b0;
    if (cfg_we || done_wr) null_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (cr_en) begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= 1'b0;
      pulse_q <= 1'b0;
      null_q  <= 1'b0;
    end else begin
      ptr_q   <= ptr_d;
      pulse_q <= pulse_d;
      null_q  <= null_d;
    end
  end

  assign cr_value   = {hi_q, lo_q};
  assign new_count  = pulse_q;
  assign null_count = null_q;
  assign first_pend = ptr_q;
endmodule

// File: rtl/cbp_sts_latch.sv
module cbp_sts_latch #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              req,
  input  logic              consume,
  input  logic [BYTE_W-1:0] sts_in,
  output logic              held,
  output logic [BYTE_W-1:0] sts_q
);
  logic held_q, held_d;
  logic cap_en;

  assign cap_en = req & ~held_q & ~clr;

  always_comb begin
    held_d = held_q;
    if (clr) begin
      held_d = 1'b0;
    end else if (consume && held_q) begin
      held_d = 1'b0;
    end else if (req && !held_q) begin
      held_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= 1'b0;
    else        held_q <= held_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sts_q <= '0;
    else if (cap_en) sts_q <= sts_in;
  end

  assign held = held_q;
endmodule

// File: rtl/cbp_rd_seq.sv
module cbp_rd_seq
  import cbp_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  acc_e              acc,
  input  logic              rd_en,
  input  logic              sts_held,
  input  logic              cnt_req,
  input  logic [CNT_W-1:0]  live_count,
  output logic [BYTE_W-1:0] byte_out,
  output logic              cnt_held
);
  logic [CNT_W-1:0]  ol_q;
  logic [CNT_W-1:0]  src;
  logic [BYTE_W-1:0] lane [2];
  logic              ptr_q, ptr_d;
  logic              held_q, held_d;
  logic              count_rd;
  logic              ol_en;
  logic              sel;

  assign count_rd = rd_en & ~sts_held;
  assign ol_en    = cnt_req & ~held_q & ~clr;
  assign src      = held_q ? ol_q : live_count;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign lane[g] = src[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    case (acc)
      ACC_HI:   sel = 1'b1;
      ACC_WORD: sel = ptr_q;
      default:  sel = 1'b0;
    endcase
  end

  assign byte_out = lane[sel];

  always_comb begin
    ptr_d  = ptr_q;
    held_d = held_q;
    if (clr) begin
      ptr_d  = 1'b0;
      held_d = 1'b0;
    end else begin
      if (count_rd) begin
        if (acc == ACC_WORD) begin
          ptr_d = ~ptr_q;
          if (ptr_q) held_d = 1'b0;
        end else begin
          held_d = 1'b0;
        end
      end
      if (cnt_req && !held_q) held_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= 1'b0;
      held_q <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      held_q <= held_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ol_q <= '0;
    else if (ol_en) ol_q <= live_count;
  end

  assign cnt_held = held_q;
endmodule

// File: rtl/cnt_byte_port.sv
module cnt_byte_port
  import cbp_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic [CFG_W-1:0]  mode_cfg,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              cnt_latch_req,
  input  logic              sts_latch_req,
  input  logic [CNT_W-1:0]  live_count,
  input  logic              out_level,
  input  logic              ce_loaded,
  output logic [CNT_W-1:0]  cr_value,
  output logic              new_count,
  output logic              null_count,
  output logic              first_byte_pending,
  output logic [CFG_W-1:0]  cfg_mode
);
  logic [CFG_W-1:0]  cfg_q;
  logic              cfg_we;
  acc_e              acc;
  logic              sts_held;
  logic [BYTE_W-1:0] sts_q;
  logic [BYTE_W-1:0] sts_in;
  logic [BYTE_W-1:0] cnt_byte;
  logic              cnt_held;
  logic              null_int;

  assign cfg_we = mode_we & (mode_cfg[CFG_W-1 -: 2] != 2'b00);
  assign acc    = acc_e'(cfg_q[CFG_W-1 -: 2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= mode_cfg;
  end

  cbp_wr_seq #(.BYTE_W(BYTE_W)) u_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .acc        (acc),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .ce_loaded  (ce_loaded),
    .cr_value   (cr_value),
    .new_count  (new_count),
    .null_count (null_int),
    .first_pend (first_byte_pending)
  );

  assign sts_in = BYTE_W'({out_level, null_int, cfg_q});

  cbp_sts_latch #(.BYTE_W(BYTE_W)) u_sts (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (cfg_we),
    .req     (sts_latch_req),
    .consume (rd_en),
    .sts_in  (sts_in),
    .held    (sts_held),
    .sts_q   (sts_q)
  );

  cbp_rd_seq #(.BYTE_W(BYTE_W)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (cfg_we),
    .acc        (acc),
    .rd_en      (rd_en),
    .sts_held   (sts_held),
    .cnt_req    (cnt_latch_req),
    .live_count (live_count),
    .byte_out   (cnt_byte),
    .cnt_held   (cnt_held)
  );

  assign rd_data    = sts_held ? sts_q : cnt_byte;
  assign null_count = null_int;
  assign cfg_mode   = cfg_q;
endmodule

// File: rtl/cbp_checker.sv
module cbp_checker
  import cbp_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_we,
  input logic [CFG_W-1:0]  mode_cfg,
  input logic              wr_en,
  input logic              ce_loaded,
  input logic              sts_latch_req,
  input logic              out_level,
  input logic [BYTE_W-1:0] rd_data,
  input logic [CNT_W-1:0]  cr_value,
  input logic              new_count,
  input logic              null_count,
  input logic              first_byte_pending,
  input logic [CFG_W-1:0]  cfg_mode,
  input logic              sts_held
);
  p_cfg_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && mode_cfg[CFG_W-1 -: 2] != 2'b00) |=> cfg_mode == $past(mode_cfg));

  p_cfg_ignore_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && mode_cfg[CFG_W-1 -: 2] == 2'b00) |=> $stable(cfg_mode));

  p_lo_only_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (new_count && cfg_mode[CFG_W-1 -: 2] == 2'b01) |-> cr_value[CNT_W-1:BYTE_W] == '0);

  p_first_no_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !mode_we && cfg_mode[CFG_W-1 -: 2] == 2'b11 && !first_byte_pending)
      |=> (first_byte_pending && !new_count));

  p_null_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && mode_cfg[CFG_W-1 -: 2] != 2'b00) |=> null_count);

  p_null_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_loaded && !mode_we && !wr_en) |=> !null_count);

  p_sts_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_latch_req && !sts_held && !mode_we) |=> rd_data[CFG_W+1] == $past(out_level));
endmodule

bind cnt_byte_port cbp_checker #(.BYTE_W(BYTE_W)) u_chk (
  .clk                (clk),
  .rst_n              (rst_n),
  .mode_we            (mode_we),
  .mode_cfg           (mode_cfg),
  .wr_en              (wr_en),
  .ce_loaded          (ce_loaded),
  .sts_latch_req      (sts_latch_req),
  .out_level          (out_level),
  .rd_data            (rd_data),
  .cr_value           (cr_value),
  .new_count          (new_count),
  .null_count         (null_count),
  .first_byte_pending (first_byte_pending),
  .cfg_mode           (cfg_mode),
  .sts_held           (sts_held)
);

// File: tb/cnt_byte_port_bench.sv
module cnt_byte_port_bench;
  logic        clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, mode_we, wr_en, rd_en, cnt_latch_req, sts_latch_req;
  logic        out_level, ce_loaded;
  logic [5:0]  mode_cfg;
  logic [7:0]  wr_data;
  logic [15:0] live_count;
  wire  [7:0]  rd_data;
  wire  [15:0] cr_value;
  wire         new_count, null_count, first_byte_pending;
  wire  [5:0]  cfg_mode;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  cnt_byte_port u_cnt_byte_port (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_cfg(mode_cfg),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .cnt_latch_req(cnt_latch_req), .sts_latch_req(sts_latch_req),
    .live_count(live_count), .out_level(out_level), .ce_loaded(ce_loaded),
    .cr_value(cr_value), .new_count(new_count), .null_count(null_count),
    .first_byte_pending(first_byte_pending), .cfg_mode(cfg_mode)
  );

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_mode(input logic [5:0] c);
    mode_cfg = c; mode_we = 1'b1; tick; mode_we = 1'b0;
  endtask

  task automatic do_wr(input logic [7:0] b);
    wr_data = b; wr_en = 1'b1; tick; wr_en = 1'b0;
  endtask

  task automatic do_rd(output logic [7:0] v);
    rd_en = 1'b1; #1; v = rd_data; tick; rd_en = 1'b0;
  endtask

  task automatic pulse_cnt_latch;
    cnt_latch_req = 1'b1; tick; cnt_latch_req = 1'b0;
  endtask

  task automatic pulse_sts_latch;
    sts_latch_req = 1'b1; tick; sts_latch_req = 1'b0;
  endtask

  task automatic pulse_load;
    ce_loaded = 1'b1; tick; ce_loaded = 1'b0;
  endtask

  function automatic logic [7:0] exp_byte(input logic [1:0] a, input logic [15:0] val,
                                          input int idx);
    if (a == 2'b10) return val[15:8];
    if (a == 2'b11 && idx == 1) return val[15:8];
    return val[7:0];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0]  rb;
    logic [15:0] v, snap;
    logic [5:0]  c;
    int          nb;
    rst_n = 1'b0; mode_we = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    cnt_latch_req = 1'b0; sts_latch_req = 1'b0; out_level = 1'b0;
    ce_loaded = 1'b0; mode_cfg = '0; wr_data = '0; live_count = '0;
    repeat (3) tick;
    rst_n = 1'b1;
    tick;

    check("R2", "reset new_count", new_count, 0);
    check("R4", "reset null_count", null_count, 0);
    check("R3", "reset first_byte_pending", first_byte_pending, 0);

    // R1: valid configuration, then one with access 00 that must be ignored
    do_mode(6'h34);
    check("R1", "cfg stored", cfg_mode, 6'h34);
    check("R4", "null set by cfg", null_count, 1);
    pulse_load;
    do_mode(6'b00_101_1);
    check("R1", "cfg 00 ignored", cfg_mode, 6'h34);
    check("R1", "cfg 00 leaves null", null_count, 0);

    // Sweep over access formats and count values
    for (int a = 1; a <= 3; a++) begin
      for (int i = 0; i < 6; i++) begin
        c  = {2'(a), 3'(i % 6), 1'(i & 1)};
        v  = 16'(i * 16'h2F1B + 16'h0180);
        nb = (a == 3) ? 2 : 1;
        do_mode(c);
        check("R1", "cfg sweep", cfg_mode, c);
        check("R4", "null after cfg", null_count, 1);
        pulse_load;
        check("R4", "null cleared by load", null_count, 0);
        if (a == 1) begin
          do_wr(v[7:0]);
          check("R2", "low-only cr", cr_value, {8'h00, v[7:0]});
          check("R2", "low-only pulse", new_count, 1);
        end else if (a == 2) begin
          do_wr(v[15:8]);
          check("R2", "high-only cr", cr_value, {v[15:8], 8'h00});
          check("R2", "high-only pulse", new_count, 1);
        end else begin
          do_wr(v[7:0]);
          check("R3", "first byte flag", first_byte_pending, 1);
          check("R3", "no pulse on first byte", new_count, 0);
          do_wr(v[15:8]);
          check("R3", "word cr", cr_value, v);
          check("R3", "word pulse", new_count, 1);
          check("R3", "flag cleared", first_byte_pending, 0);
        end
        check("R4", "null set by count write", null_count, 1);
        tick;
        check("R2", "pulse single cycle", new_count, 0);
        pulse_load;
        check("R4", "null cleared after write", null_count, 0);

        // R5: live reads
        live_count = ~v;
        for (int k = 0; k < nb; k++) begin
          do_rd(rb);
          check("R5", "live byte", rb, exp_byte(2'(a), ~v, k));
        end
        // R6/R7: latch, second latch ignored
        live_count = v ^ 16'h1234;
        pulse_cnt_latch;
        snap = live_count;
        live_count = v ^ 16'h5A5A;
        pulse_cnt_latch;
        live_count = live_count + 16'd3;
        for (int k = 0; k < nb; k++) begin
          do_rd(rb);
          check("R7", "frozen byte, first latch wins", rb, exp_byte(2'(a), snap, k));
        end
        for (int k = 0; k < nb; k++) begin
          do_rd(rb);
          check("R6", "follows live after full read", rb, exp_byte(2'(a), live_count, k));
        end
      end
    end

    // R8/R9: status captured first, then count
    do_mode(6'h36);
    out_level = 1'b1;
    pulse_sts_latch;
    out_level = 1'b0;
    pulse_load;
    pulse_sts_latch;
    live_count = 16'hBEEF;
    pulse_cnt_latch;
    live_count = 16'h0102;
    do_rd(rb);
    check("R8", "status byte, second request ignored", rb, 8'hF6);
    do_rd(rb);
    check("R9", "count low after status", rb, 8'hEF);
    do_rd(rb);
    check("R9", "count high after status", rb, 8'hBE);
    do_rd(rb);
    check("R9", "live after latches", rb, 8'h02);
    do_rd(rb);

    // R9: count latched before status, status still read first
    live_count = 16'h1234;
    pulse_cnt_latch;
    out_level = 1'b1;
    pulse_sts_latch;
    live_count = 16'h0000;
    do_rd(rb);
    check("R9", "status first despite order", rb, 8'hB6);
    do_rd(rb);
    check("R9", "count low", rb, 8'h34);
    do_rd(rb);
    check("R9", "count high", rb, 8'h12);

    // R10: interleaved read and write pointers
    live_count = 16'hC3A5;
    do_rd(rb);
    check("R10", "read low", rb, 8'hA5);
    do_wr(8'h11);
    check("R10", "write low pending", first_byte_pending, 1);
    do_rd(rb);
    check("R10", "read high", rb, 8'hC3);
    do_wr(8'h22);
    check("R10", "write word", cr_value, 16'h2211);
    do_wr(8'h33);
    do_rd(rb);
    check("R10", "read low after write low", rb, 8'hA5);
    do_wr(8'h44);
    check("R10", "write word 2", cr_value, 16'h4433);
    do_rd(rb);
    check("R10", "read high after write high", rb, 8'hC3);

    // R11: configuration write discards latches and resets pointers
    live_count = 16'h7788;
    pulse_cnt_latch;
    pulse_sts_latch;
    live_count = 16'h99AA;
    do_mode(6'h36);
    do_rd(rb);
    check("R11", "latches discarded", rb, 8'hAA);
    do_mode(6'h36);
    do_rd(rb);
    check("R11", "read pointer reset", rb, 8'hAA);
    do_wr(8'h55);
    do_mode(6'h36);
    check("R11", "write pointer reset", first_byte_pending, 0);
    do_wr(8'h66);
    check("R11", "restart at low byte", first_byte_pending, 1);
    check("R11", "no pulse on restart", new_count, 0);

    // R4: set wins over simultaneous load
    do_mode(6'h36);
    pulse_load;
    do_wr(8'h01);
    ce_loaded = 1'b1;
    do_wr(8'h02);
    ce_loaded = 1'b0;
    check("R4", "set wins over load", null_count, 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule